// File: doc/BRIEF.md
# Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds one table of two-bit saturating counters. The table is indexed by the word-address bits of the branch PC XORed with a global history register, which records the outcomes of the most recent resolved branches. Because the index mixes address and recent path, the same static branch can hold several independent counters, one for each history pattern that reaches it. This lets it learn short repeating patterns, such as an inner loop that is taken three times and then falls through.

The block has two ports:

- **Predict port.** The fetch stage presents PC bits `IDX_W+1` down to 2. It reads back a taken or not-taken direction in the same cycle, with no register on the path.
- **Update port.** When a branch resolves, the pipeline presents its PC bits and its actual outcome. On the next clock edge the selected counter moves one step toward that outcome and the outcome enters the history register.

The caller does not pass the byte-offset bits or any bits above the index field. No tags are kept, so distinct branches that hash to the same entry share a counter. Deciding whether an instruction is a branch, and predicting its target, happen elsewhere.

Each counter is a four-state machine:

| State | Value | Meaning | Taken outcome moves to | Not-taken outcome moves to |
|---|---|---|---|---|
| `CTR_SNT` | 0 | strongly not-taken | `CTR_WNT` | stays |
| `CTR_WNT` | 1 | weakly not-taken | `CTR_WT` | `CTR_SNT` |
| `CTR_WT` | 2 | weakly taken | `CTR_ST` | `CTR_WNT` |
| `CTR_ST` | 3 | strongly taken | stays | `CTR_WT` |

Reset places every counter in `CTR_WNT` and clears the history.

Top module: `gshare_predictor`

## Requirements
- R1: While reset is low and after it is released, every counter is in state 1 (weakly not-taken) and the history register is all zeros, so every PC predicts not-taken until an update occurs.
- R2: The table index equals the supplied PC bits `[IDX_W+1:2]` XOR the history register, with the history zero-extended on the left when `HIST_W < IDX_W`. No tags are compared, so two PCs with the same index share a counter.
- R3: Counter encoding is 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken. `pred_taken` is 1 exactly when the indexed counter holds 2 or 3.
- R4: An update with `upd_taken`=1 increments the indexed counter by one, and a counter at 3 stays at 3.
- R5: An update with `upd_taken`=0 decrements the indexed counter by one, and a counter at 0 stays at 0.
- R6: On an update, the history register shifts left by one, the outcome (taken = 1) enters bit 0 and the oldest bit is dropped. In a cycle without an update, the history is unchanged.
- R7: When a prediction and an update select the same entry in one cycle, `pred_taken` reflects the counter value before that update. Both ports use the history value from before the edge.
- R8: From a strongly taken counter, one not-taken update leaves the prediction taken, and a second consecutive not-taken update on that entry makes it not-taken.
- R9: For a nested loop whose inner branch goes taken, taken, taken, not-taken, followed by an always-taken outer branch, prediction has zero mispredictions after a warm-up of ten outer iterations (with `HIST_W`=8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | IDX_W | PC bits IDX_W+1..2 of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, combinational from `pred_pc` |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | IDX_W | PC bits IDX_W+1..2 of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The assertions assume that `upd_valid` and `upd_taken` carry known values on every edge after reset, and that at most one update arrives per cycle. The port structure already guarantees the one-update limit. The assertions do not assume that an update's PC was predicted earlier under the same history: they check each counter step and each history shift against whatever entry the update actually selected. The bench changes every input half a period away from the rising edge, always drives defined values, and presents each resolved branch in the same cycle as its prediction. Its arithmetic model therefore sees the same history the design uses, including across a reset applied in the middle of the run.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    // Two-bit hysteresis counter states; the numeric value is the encoding.
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;

    // Next-state function of one counter given a resolved outcome.
    function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
        ctr_t nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    // Direction implied by a counter state.
    function automatic logic ctr_dir(input ctr_t cur);
        logic dir;
        unique case (cur)
            CTR_SNT, CTR_WNT: dir = 1'b0;
            CTR_WT,  CTR_ST:  dir = 1'b1;
        endcase
        return dir;
    endfunction

endpackage

// File: rtl/bp_index.sv
`timescale 1ns/1ps
// Folds the global history into the PC word-address bits.
module bp_index #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic [IDX_W+1:2]  pc_bits,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    generate
        if (HIST_W == IDX_W) begin : g_full
            assign idx = pc_bits ^ hist;
        end else begin : g_pad
            localparam int PAD_W = IDX_W - HIST_W;
            assign idx = pc_bits ^ {{PAD_W{1'b0}}, hist};
        end
    endgenerate
endmodule

// File: rtl/bp_history.sv
`timescale 1ns/1ps
// Global outcome history: newest outcome in bit 0.
module bp_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W == 1) begin : g_one
            assign hist_d = bit_in;
        end else begin : g_many
            assign hist_d = {hist_q[HIST_W-2:0], bit_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;
endmodule

// File: rtl/bp_ctr_table.sv
`timescale 1ns/1ps
// Untagged table of saturating counters, one read and one update port.
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_t             wr_old,
    output ctr_t             cells [ENTRIES]
);
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
            ctr_t state_q;
            ctr_t state_d;
            logic hit;

            assign hit = wr_en && (wr_idx == IDX_W'(e));

            always_comb begin
                state_d = state_q;
                if (hit) begin
                    state_d = ctr_next(state_q, wr_taken);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state_q <= CTR_WNT;
                end else begin
                    state_q <= state_d;
                end
            end

            assign cells[e] = state_q;
        end
    endgenerate

    // Reads see the registered values, i.e. the state before this edge.
    assign rd_ctr = cells[rd_idx];
    assign wr_old = cells[wr_idx];
endmodule

// File: rtl/gshare_predictor.sv
`timescale 1ns/1ps
// Correlated direction predictor: PC XOR global history indexes counters.
module gshare_predictor
    import bp_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W+1:2] pred_pc,
    output logic             pred_taken,
    input  logic             upd_valid,
    input  logic [IDX_W+1:2] upd_pc,
    input  logic             upd_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W-1:0] ghr_q;
    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    ctr_t              pred_ctr;
    ctr_t              upd_old;
    ctr_t              ctr_tbl [ENTRIES];

    bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_pidx (
        .pc_bits (pred_pc),
        .hist    (ghr_q),
        .idx     (pred_idx)
    );

    bp_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_uidx (
        .pc_bits (upd_pc),
        .hist    (ghr_q),
        .idx     (upd_idx)
    );

    bp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_ctr   (pred_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .wr_old   (upd_old),
        .cells    (ctr_tbl)
    );

    bp_history #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (ghr_q)
    );

    always_comb begin
        pred_taken = ctr_dir(pred_ctr);
    end
endmodule

// File: rtl/bp_checker.sv
`timescale 1ns/1ps
module bp_checker
    import bp_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8,
    localparam int ENTRIES = 1 << IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [IDX_W-1:0]  upd_idx,
    input ctr_t              upd_old,
    input logic [HIST_W-1:0] ghr,
    input ctr_t              tbl [ENTRIES]
);
    logic              q_v;
    logic              q_taken;
    logic [IDX_W-1:0]  q_idx;
    logic [1:0]        q_old;
    logic [HIST_W-1:0] q_ghr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v     <= 1'b0;
            q_taken <= 1'b0;
            q_idx   <= '0;
            q_old   <= 2'd1;
            q_ghr   <= '0;
        end else begin
            q_v     <= upd_valid;
            q_taken <= upd_taken;
            q_idx   <= upd_idx;
            q_old   <= upd_old;
            q_ghr   <= ghr;
        end
    end

    AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && q_taken && q_old != 2'd3) |-> (tbl[q_idx] == q_old + 2'd1)); // R4
    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && q_taken && q_old == 2'd3) |-> (tbl[q_idx] == CTR_ST)); // R4
    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && !q_taken && q_old != 2'd0) |-> (tbl[q_idx] == q_old - 2'd1)); // R5
    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (q_v && !q_taken && q_old == 2'd0) |-> (tbl[q_idx] == CTR_SNT)); // R5
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        q_v |-> (ghr == HIST_W'({q_ghr, q_taken}))); // R6
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !q_v |-> (ghr == q_ghr)); // R6
endmodule

bind gshare_predictor bp_checker #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .upd_idx   (upd_idx),
    .upd_old   (upd_old),
    .ghr       (ghr_q),
    .tbl       (ctr_tbl)
);

// File: tb/sim_gshare_predictor.sv
`timescale 1ns/1ps
module sim_gshare_predictor;
    localparam int IDX_W  = 8;
    localparam int HIST_W = 8;
    localparam int ENT    = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W+1:2] pred_pc = '0;
    logic [IDX_W+1:2] upd_pc = '0;
    logic             upd_valid = 1'b0;
    logic             upd_taken = 1'b0;
    logic             pred_taken;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int mdl [ENT];
    logic [HIST_W-1:0] mghr;

    always #10 clk = ~clk;

    gshare_predictor #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic int midx(input logic [IDX_W-1:0] pcb);
        return int'(pcb ^ mghr);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < ENT; i++) mdl[i] = 1;
        mghr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Predict only; no update in this cycle.
    task automatic peek(input logic [IDX_W-1:0] pcb, input string tag);
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = pcb;
        #2;
        chk(tag, pred_taken, mdl[midx(pcb)] >= 2);
    endtask

    // Predict and resolve the same branch in one cycle.
    task automatic branch(input logic [IDX_W-1:0] pcb, input logic tk,
                          input string tag, output logic got);
        int ix;
        @(negedge clk);
        pred_pc = pcb;
        upd_pc = pcb;
        upd_valid = 1'b1;
        upd_taken = tk;
        #2;
        got = pred_taken;
        ix = midx(pcb);
        chk(tag, pred_taken, mdl[ix] >= 2);
        if (tk) mdl[ix] = (mdl[ix] == 3) ? 3 : mdl[ix] + 1;
        else    mdl[ix] = (mdl[ix] == 0) ? 0 : mdl[ix] - 1;
        mghr = {mghr[HIST_W-2:0], tk};
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic got;
        logic [15:0] lf;
        logic [IDX_W-1:0] p;
        model_reset();
        do_reset();

        // R1: every entry predicts not-taken after reset
        for (int i = 0; i < ENT; i++) peek(IDX_W'(i), "R1 reset sweep");

        // R2 R3 R4 R5 R6 R7: pseudo-random branch stream against the model
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            p = {4'b1010, lf[3:0]};
            branch(p, lf[9] | lf[8], "R2 R3 R4 R5 R6 R7 stream", got);
            if (n % 50 == 0) peek({lf[11:4]}, "R2 R6 side read");
        end

        // R1: reset in the middle clears counters and history
        do_reset();
        for (int i = 0; i < ENT; i++) peek(IDX_W'(i), "R1 mid-run reset sweep");

        // R8: hysteresis on entry 0x35 ^ 0xFF
        p = 8'h35;
        for (int n = 0; n < 12; n++) branch(p, 1'b1, "R4 train", got);
        branch(p, 1'b0, "R8 first miss", got);
        chk("R8 first miss keeps taken", got, 1'b1);
        peek(p ^ 8'h01, "R8 after one miss");
        chk("R8 still taken", pred_taken, 1'b1);
        branch(p ^ 8'h01, 1'b0, "R8 second miss", got);
        peek(p ^ 8'h03, "R8 after two misses");
        chk("R8 flipped", pred_taken, 1'b0);

        // R5 saturation at 0 with repeated not-taken
        do_reset();
        for (int n = 0; n < 6; n++) branch(8'h77, 1'b0, "R5 saturate low", got);
        chk("R5 stays not-taken", got, 1'b0);

        // R9: nested loop, inner T T T N then outer T
        do_reset();
        for (int it = 0; it < 30; it++) begin
            for (int k = 0; k < 4; k++) begin
                branch(8'h40, (k != 3), "R9 inner model", got);
                if (it >= 10) chk("R9 inner no mispredict", got, (k != 3));
            end
            branch(8'h41, 1'b1, "R9 outer model", got);
            if (it >= 10) chk("R9 outer no mispredict", got, 1'b1);
        end

        @(negedge clk);
        upd_valid = 1'b0;
        done = 1;
        summary();
        $finish;
    end
endmodule